// File: doc/BRIEF.md
# Triggered Event Frame Packer

This block turns a readout start into a fixed 32-word frame of 16-bit words, one word per clock. Each word carries a two-bit control code in its top bits and a 14-bit field below it.

A frame has three parts, in this order:
- two time-stamp words, high half first;
- one identifier word that combines the channel number and the board number;
- 29 payload words.

The payload words take samples straight from the tap of an external raw-data delay line. The delay of that line sets the offset of about 19 samples between the trigger point and the first captured sample, so the block adds no delay of its own.

A free-running counter gives the time stamp. It counts clocks since the last spill boundary, a spill pulse clears it, and it holds at a parameterised limit. The default limit is 1,250,000 clocks, one spill at 125 MHz. The block captures the time stamp and both identifiers when it accepts a start, so later changes on those inputs do not reach a frame already under way. It ignores a start that arrives while a frame is being emitted. Arbitration between channels happens downstream.

The sequencer has five states:
- IDLE: waits for a start.
- TS_HIGH: emits the upper time-stamp word.
- TS_LOW: emits the lower time-stamp word.
- ID_WORD: emits the identifier word.
- PAYLOAD: emits the 29 sample words.

Its transitions are:
- IDLE to TS_HIGH on a start; it stays in IDLE otherwise.
- TS_HIGH to TS_LOW, then TS_LOW to ID_WORD, then ID_WORD to PAYLOAD, each taken unconditionally.
- PAYLOAD back to IDLE after the 29th payload word.

Top module: `evt_frame_packer`

## Requirements
- R1: While reset is held and in every cycle after reset until the first start, valid_o, sof_o and eof_o are low.
- R2: A start accepted in IDLE produces exactly 32 consecutive valid words, starting in the clock after the start. sof_o is high on word 0 only and eof_o is high on word 31 only.
- R3: Word 0 is {2'b11, 7'b0, ts[20:14]} and word 1 is {2'b11, ts[13:0]}, where ts is the 21-bit time-stamp counter value in the cycle the start was accepted.
- R4: Word 2 is {2'b10, 1'b0, board[8:0], channel[3:0]}, using the identifier inputs sampled in the cycle the start was accepted.
- R5: Words 3 to 30 are {2'b00, samp_i} and word 31 is {2'b01, samp_i}, where samp_i is the value present in the same cycle as the word.
- R6: The time-stamp counter is 0 in the first cycle after reset and increments by one each clock. In the cycle after a spill pulse it reads 0. It holds at TS_LIMIT.
- R7: A start during a frame, including during the eof_o cycle, is ignored: the frame keeps its 32 words and valid_o is low in the cycle after eof_o.
- R8: A spill pulse or a change of the identifier inputs during a frame does not alter that frame's time-stamp or identifier words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Readout start pulse |
| spill_i | input | 1 | Spill boundary pulse, clears the time stamp |
| ch_id_i | input | 4 | Channel number within the board |
| board_id_i | input | 9 | Board number |
| samp_i | input | 14 | Sample from the delayed raw-data tap |
| word_o | output | 16 | Frame word: control code in the top two bits |
| valid_o | output | 1 | Word strobe |
| sof_o | output | 1 | First word of a frame |
| eof_o | output | 1 | Last word of a frame |

## Verification
A sequencer stuck or skipping a state shows up at the ports as a control code out of order, and it is visible on the very word where it happens. It also changes the gap between sof_o and eof_o, which the checker measures on every frame. A wrong payload count appears on eof_o within 29 clocks. A time-stamp counter that misses a clear or a hold appears only in the header of the next frame. The bench therefore starts frames right after spill pulses and after the counter has saturated.

// File: rtl/efp_pkg.sv
package efp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TS_HI,
        ST_TS_LO,
        ST_ID,
        ST_DATA
    } efp_state_e;

    localparam int CTL_W = 2;
    localparam logic [CTL_W-1:0] CTL_TIME = 2'b11;
    localparam logic [CTL_W-1:0] CTL_IDW  = 2'b10;
    localparam logic [CTL_W-1:0] CTL_DATA = 2'b00;
    localparam logic [CTL_W-1:0] CTL_LAST = 2'b01;
    localparam int HDR_WORDS = 3;
endpackage

// File: rtl/efp_spill_timer.sv
module efp_spill_timer #(
    parameter int TS_W     = 21,
    parameter int TS_LIMIT = 1250000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            spill_i,
    output logic [TS_W-1:0] ts_o
);
    localparam logic [TS_W-1:0] LIMIT = TS_W'(TS_LIMIT);

    logic [TS_W-1:0] ts_q;

    always_ff @(posedge clk) begin
        if (!rst_n || spill_i) begin
            ts_q <= '0;
        end else if (ts_q != LIMIT) begin
            ts_q <= ts_q + 1'b1;
        end
    end

    assign ts_o = ts_q;
endmodule

// File: rtl/efp_seq.sv
module efp_seq
    import efp_pkg::*;
#(
    parameter int PAY_WORDS = 29,
    localparam int IDX_W    = $clog2(PAY_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output efp_state_e       state_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             accept_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAY_WORDS - 1);

    efp_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        idx_d    = idx_q;
        accept_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    accept_o = 1'b1;
                    state_d  = ST_TS_HI;
                end
            end
            ST_TS_HI: state_d = ST_TS_LO;
            ST_TS_LO: state_d = ST_ID;
            ST_ID: begin
                state_d = ST_DATA;
                idx_d   = '0;
            end
            ST_DATA: begin
                if (idx_q == LAST_IDX) begin
                    state_d = ST_IDLE;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign state_o = state_q;
    assign idx_o   = idx_q;
endmodule

// File: rtl/efp_word_fmt.sv
module efp_word_fmt
    import efp_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int TS_W      = 21,
    parameter int CH_W      = 4,
    parameter int BD_W      = 9,
    parameter int PAY_WORDS = 29,
    localparam int SAMP_W   = WORD_W - CTL_W,
    localparam int IDX_W    = $clog2(PAY_WORDS),
    localparam int ID_PAD   = SAMP_W - CH_W - BD_W,
    localparam int TS_PAD   = 2 * SAMP_W - TS_W
) (
    input  efp_state_e        state_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [TS_W-1:0]   ts_i,
    input  logic [CH_W-1:0]   ch_i,
    input  logic [BD_W-1:0]   bd_i,
    input  logic [SAMP_W-1:0] samp_i,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o,
    output logic              sof_o,
    output logic              eof_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAY_WORDS - 1);

    logic [2*SAMP_W-1:0] ts_ext;
    assign ts_ext = {{TS_PAD{1'b0}}, ts_i};

    always_comb begin
        word_o  = '0;
        valid_o = 1'b1;
        sof_o   = 1'b0;
        eof_o   = 1'b0;
        unique case (state_i)
            ST_IDLE: valid_o = 1'b0;
            ST_TS_HI: begin
                sof_o  = 1'b1;
                word_o = {CTL_TIME, ts_ext[2*SAMP_W-1:SAMP_W]};
            end
            ST_TS_LO: word_o = {CTL_TIME, ts_ext[SAMP_W-1:0]};
            ST_ID:    word_o = {CTL_IDW, {ID_PAD{1'b0}}, bd_i, ch_i};
            ST_DATA: begin
                if (idx_i == LAST_IDX) begin
                    eof_o  = 1'b1;
                    word_o = {CTL_LAST, samp_i};
                end else begin
                    word_o = {CTL_DATA, samp_i};
                end
            end
            default: valid_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/evt_frame_packer.sv
module evt_frame_packer
    import efp_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int FRAME_WORDS = 32,
    parameter int TS_W        = 21,
    parameter int TS_LIMIT    = 1250000,
    parameter int CH_W        = 4,
    parameter int BD_W        = 9,
    localparam int SAMP_W     = WORD_W - CTL_W,
    localparam int PAY_WORDS  = FRAME_WORDS - HDR_WORDS,
    localparam int IDX_W      = $clog2(PAY_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              spill_i,
    input  logic [CH_W-1:0]   ch_id_i,
    input  logic [BD_W-1:0]   board_id_i,
    input  logic [SAMP_W-1:0] samp_i,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o,
    output logic              sof_o,
    output logic              eof_o
);
    logic [TS_W-1:0]  ts_now, ts_cap;
    logic [CH_W-1:0]  ch_cap;
    logic [BD_W-1:0]  bd_cap;
    efp_state_e       state;
    logic [IDX_W-1:0] idx;
    logic             accept;

    efp_spill_timer #(.TS_W(TS_W), .TS_LIMIT(TS_LIMIT)) timer_i (
        .clk(clk), .rst_n(rst_n), .spill_i(spill_i), .ts_o(ts_now)
    );

    efp_seq #(.PAY_WORDS(PAY_WORDS)) seq_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .state_o(state), .idx_o(idx), .accept_o(accept)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_cap <= '0;
            ch_cap <= '0;
            bd_cap <= '0;
        end else if (accept) begin
            ts_cap <= ts_now;
            ch_cap <= ch_id_i;
            bd_cap <= board_id_i;
        end
    end

    efp_word_fmt #(
        .WORD_W(WORD_W), .TS_W(TS_W), .CH_W(CH_W), .BD_W(BD_W), .PAY_WORDS(PAY_WORDS)
    ) fmt_i (
        .state_i(state), .idx_i(idx), .ts_i(ts_cap), .ch_i(ch_cap), .bd_i(bd_cap),
        .samp_i(samp_i), .word_o(word_o), .valid_o(valid_o), .sof_o(sof_o), .eof_o(eof_o)
    );
endmodule

// File: rtl/efp_checker.sv
module efp_checker #(
    parameter int WORD_W      = 16,
    parameter int FRAME_WORDS = 32,
    parameter int TS_W        = 21
) (
    input logic              clk,
    input logic              rst_n,
    input logic              spill_i,
    input logic [WORD_W-1:0] word_o,
    input logic              valid_o,
    input logic              sof_o,
    input logic              eof_o,
    input logic [TS_W-1:0]   ts_now
);
    logic [7:0] seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (sof_o) begin
            seen_q <= 8'd1;
        end else if (valid_o) begin
            seen_q <= seen_q + 8'd1;
        end
    end

    assert_frame_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        eof_o |-> (seen_q == 8'(FRAME_WORDS - 1)));

    assert_sof_stream_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sof_o |=> (valid_o && !sof_o));

    assert_time_ctl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sof_o |-> (valid_o && word_o[WORD_W-1 -: 2] == 2'b11));

    assert_last_ctl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        eof_o |-> (valid_o && word_o[WORD_W-1 -: 2] == 2'b01));

    assert_spill_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        spill_i |=> (ts_now == '0));

    assert_idle_after_eof_R7: assert property (@(posedge clk) disable iff (!rst_n)
        eof_o |=> !valid_o);
endmodule

bind evt_frame_packer efp_checker #(
    .WORD_W(WORD_W), .FRAME_WORDS(FRAME_WORDS), .TS_W(TS_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .spill_i(spill_i), .word_o(word_o),
    .valid_o(valid_o), .sof_o(sof_o), .eof_o(eof_o), .ts_now(ts_now)
);

// File: tb/evt_frame_packer_tb.sv
module evt_frame_packer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 600;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        spill_i = 1'b0;
    logic [3:0]  ch_id_i = '0;
    logic [8:0]  board_id_i = '0;
    logic [13:0] samp_i = '0;
    logic [15:0] word_o;
    logic        valid_o, sof_o, eof_o;

    int checks = 0;
    int fails  = 0;
    int ts_model = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_frame_packer #(.TS_LIMIT(LIMIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .spill_i(spill_i),
        .ch_id_i(ch_id_i), .board_id_i(board_id_i), .samp_i(samp_i),
        .word_o(word_o), .valid_o(valid_o), .sof_o(sof_o), .eof_o(eof_o)
    );

    // R6 counter model: clears on reset or spill, holds at LIMIT
    always @(posedge clk) begin
        if (!rst_n || spill_i) ts_model <= 0;
        else if (ts_model != LIMIT) ts_model <= ts_model + 1;
    end

    // {channel, board, seed}
    localparam logic [26:0] VEC [0:5] = '{
        {4'd0,  9'd1,   14'd0},
        {4'd15, 9'd400, 14'h3FFF},
        {4'd7,  9'd255, 14'd1234},
        {4'd1,  9'd511, 14'd77},
        {4'd9,  9'd2,   14'h2AAA},
        {4'd4,  9'd300, 14'h1555}
    };

    function automatic logic [13:0] pat(input logic [13:0] seed, input int k);
        return seed + 14'(k * k * 3 + k * 11);
    endfunction

    task automatic check(input string req, input logic [18:0] act, input logic [18:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // poke: start during frame (R7) and spill/ID changes during header (R8)
    task automatic run_frame(input logic [3:0] ch, input logic [8:0] bd,
                             input logic [13:0] seed, input bit poke, input int ts_force);
        logic [20:0] ts;
        logic [15:0] exp_w;
        @(negedge clk);
        ch_id_i = ch; board_id_i = bd; start_i = 1'b1;
        ts = (ts_force >= 0) ? 21'(ts_force) : 21'(ts_model);
        for (int k = 0; k < 32; k++) begin
            @(negedge clk);
            start_i = poke && (k == 10 || k == 31);
            spill_i = poke && (k == 0);
            if (poke && k == 0) begin
                ch_id_i = ~ch; board_id_i = ~bd;
            end
            samp_i = pat(seed, k);
            #1;
            if (k == 0)       exp_w = {2'b11, 7'b0, ts[20:14]};
            else if (k == 1)  exp_w = {2'b11, ts[13:0]};
            else if (k == 2)  exp_w = {2'b10, 1'b0, bd, ch};
            else if (k == 31) exp_w = {2'b01, samp_i};
            else              exp_w = {2'b00, samp_i};
            if (k < 2)       check(poke ? "R3/R8 time word" : "R3 time word", {valid_o, sof_o, eof_o, word_o}, {1'b1, k == 0, 1'b0, exp_w});
            else if (k == 2) check(poke ? "R4/R8 id word" : "R4 id word", {valid_o, sof_o, eof_o, word_o}, {3'b100, exp_w});
            else             check("R2/R5 payload word", {valid_o, sof_o, eof_o, word_o}, {1'b1, 1'b0, k == 31, exp_w});
        end
        @(negedge clk);
        start_i = 1'b0; spill_i = 1'b0;
        #1;
        check(poke ? "R7 idle after eof" : "R2 idle after eof", {16'h0, valid_o, sof_o, eof_o}, 19'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R2 actual=timeout expected=completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: outputs quiet in reset and after release
        repeat (3) @(negedge clk);
        #1 check("R1 in reset", {16'h0, valid_o, sof_o, eof_o}, 19'h0);
        @(negedge clk); rst_n = 1'b1;
        repeat (4) begin
            @(negedge clk); #1;
            check("R1 after reset", {16'h0, valid_o, sof_o, eof_o}, 19'h0);
        end
        // R6: counter started at 0, reads 5 after five edges since release
        run_frame(4'd3, 9'd17, 14'd5, 1'b0, 5);

        // table walk
        for (int i = 0; i < 6; i++) begin
            if (i == 2) begin
                @(negedge clk); spill_i = 1'b1;
                @(negedge clk); spill_i = 1'b0;
            end
            run_frame(VEC[i][26:23], VEC[i][22:14], VEC[i][13:0], 1'b0, -1);
        end

        // R6: start right after spill sees 0
        @(negedge clk); spill_i = 1'b1;
        run_frame(4'd2, 9'd33, 14'd9, 1'b0, 0);

        // R7/R8: starts during frame ignored, mid-frame spill and ID changes
        run_frame(4'd12, 9'd345, 14'd444, 1'b1, -1);
        // back-to-back start right after idle
        run_frame(4'd6, 9'd6, 14'd66, 1'b0, -1);

        // R6: saturation at LIMIT
        repeat (LIMIT + 50) @(negedge clk);
        run_frame(4'd11, 9'd99, 14'd1000, 1'b0, LIMIT);

        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule